// File: doc/BRIEF.md
# Block Hamming ECC Engine for NAND Data Streams

This engine sits on the data-phase byte stream of a NAND flash path and computes a single-error-correcting, double-error-detecting Hamming code for every 512-byte block that passes. A session opens with a start pulse. The pulse stands for a transfer that begins on a 512-byte-aligned address and fixes the direction of the session. Each byte accepted after the pulse is folded into a running row and column parity at its offset within the current block. When the 512th byte of a block is accepted, the 3-byte code for that block is stored in a per-block slot.

In a write session the stored codes are presented at the outputs, so the host can place them in the spare area behind the page data. In a read session the host hands the engine the codes it fetched from the spare area, one block at a time. The engine compares each one with the code it computed and records a per-block verdict: clean, a correctable single data-bit error with its byte offset and bit number, an error confined to the code bytes, or uncorrectable. A block that reads back entirely erased, with all data bytes and all code bytes at 0xFF, counts as clean. The engine never modifies data; it only locates the bad bit, and software flips it.

Four slots cover a 2048-byte page. The byte that carries the last flag closes the session. A session also closes by itself once all four slots are full.

Top module: `hamming_ecc_engine`

## Requirements
- R1: After reset, busy is 0, blocksDone is 0, and every code, status, byte-offset and bit-number output is 0.
- R2: A start pulse opens a session in the direction given by isRead (1 = read), and one cycle later busy=1, blocksDone=0 and all status fields read 0. A byte strobed in the same cycle as the start pulse is ignored, and the next accepted byte is offset 0 of block 0.
- R3: The 24-bit code of a block holds 18 row bits and 6 column bits. For each offset bit i (0..8), code bit 2i+1 is the XOR of all data bits in bytes whose offset has bit i set, and code bit 2i is the XOR over bytes whose offset has bit i clear. For each bit-number bit j (0..2), code bit 18+2j+1 is the XOR of data bit positions whose number has bit j set across the block, and code bit 18+2j is the XOR over positions whose number has bit j clear.
- R4: The cycle after the 512th accepted byte of block k, codeVec bits [24k+23:24k] hold that block's code and blocksDone has risen by one. blocksDone never rises by more than one per cycle.
- R5: The accepted byte carrying lastFlag ends the session (busy=0 the next cycle). If that byte is not the 512th of its block, the partial block yields no code and blocksDone is unchanged. Bytes strobed while no session is open have no effect on blocksDone or codeVec.
- R6: Once 4 blocks are complete the session closes on its own. Further bytes are ignored, and blocksDone never exceeds 4.
- R7: A compare request (eccValid with eccIdx and eccCode) in a read session sets the status of block eccIdx the next cycle. Status 0 (clean) results when eccCode equals the computed code.
- R8: When the XOR of eccCode and the computed code has exactly one bit set in each of the 12 pairs {2p, 2p+1}, the status becomes 1 (corrected data bit). The byte offset then reads the odd row bits 2i+1 as offset bit i, and the bit number reads the odd column bits 18+2j+1 as bit j.
- R9: When the XOR has exactly one bit set, the status becomes 2 (error in the code bytes).
- R10: Any other nonzero XOR sets status 3 (uncorrectable). For every status other than 1, the byte-offset and bit-number fields read 0.
- R11: A block whose 512 data bytes were all 0xFF, compared against eccCode 0xFFFFFF, gets status 0.
- R12: Compare requests in a write session, and requests for a block index not yet completed, leave every status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startBlk | input | 1 | Opens a session at a 512-byte-aligned transfer |
| isRead | input | 1 | Direction sampled with startBlk (1 = read) |
| byteValid | input | 1 | Data byte strobe |
| dataByte | input | 8 | Data-phase byte |
| lastFlag | input | 1 | Marks the final byte of the transfer |
| eccValid | input | 1 | Compare request strobe |
| eccIdx | input | 2 | Block index of the compare request |
| eccCode | input | 24 | Code read back from the spare area |
| busy | output | 1 | Session open |
| blocksDone | output | 3 | Blocks completed in this session |
| codeVec | output | 96 | Computed code per block, block k at bits [24k+23:24k] |
| statVec | output | 8 | Status per block, 2 bits each |
| fixByteVec | output | 36 | Corrected byte offset per block, 9 bits each |
| fixBitVec | output | 12 | Corrected bit number per block, 3 bits each |

## Verification
A wrong offset counter or a lost byte shifts parity between row pairs. That shows up in codeVec the cycle after the 512th byte, and only the bit-exact comparison against the bench's bit-by-bit reference code catches it. A fault in the block counter appears at once on blocksDone and in which slot of codeVec changes. A wrong decode shows up in statVec and the fix fields one cycle after the compare strobe. Random pages with injected single, double and code-byte flips cover each verdict with a known expected location.

// File: rtl/hecc_pkg.sv
`timescale 1ns/1ps
package hecc_pkg;
  localparam int BLK_BYTES = 512;
  localparam int NUM_SLOTS = 4;
  localparam int DATA_W    = 8;
  localparam int OFS_W     = $clog2(BLK_BYTES);
  localparam int BIT_W     = $clog2(DATA_W);
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int ROW_W     = 2 * OFS_W;
  localparam int COL_W     = 2 * BIT_W;
  localparam int CODE_W    = ROW_W + COL_W;

  typedef enum logic [1:0] {
    ST_CLEAN   = 2'd0,
    ST_FIXED   = 2'd1,
    ST_CODEFLT = 2'd2,
    ST_BAD     = 2'd3
  } stat_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              clrAll;
    logic              accum;
    logic              finish;
    logic              drop;
    logic              dec;
    logic [OFS_W-1:0]  ofs;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] decSlot;
  } ctl_s;

  // fold the per-bit column accumulator into column parity pairs
  function automatic logic [COL_W-1:0] colFold(input logic [DATA_W-1:0] acc);
    logic [COL_W-1:0] r;
    r = '0;
    for (int k = 0; k < DATA_W; k++) begin
      for (int j = 0; j < BIT_W; j++) begin
        if (k[j]) r[2*j+1] = r[2*j+1] ^ acc[k];
        else      r[2*j]   = r[2*j]   ^ acc[k];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/hecc_ctrl.sv
`timescale 1ns/1ps
module hecc_ctrl
  import hecc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startBlk,
  input  logic              isRead,
  input  logic              byteValid,
  input  logic              lastFlag,
  input  logic              eccValid,
  input  logic [SLOT_W-1:0] eccIdx,
  output ctl_s              ctl,
  output logic              busy,
  output logic [SLOT_W:0]   blocksDone
);
  logic              active;
  logic              readMode;
  logic [OFS_W-1:0]  ofs;
  logic [SLOT_W:0]   doneCnt;
  logic              accept;
  logic              finish;
  logic              lastSlot;

  assign accept   = active && byteValid && !startBlk;
  assign finish   = accept && (ofs == OFS_W'(BLK_BYTES - 1));
  assign lastSlot = (doneCnt == (SLOT_W+1)'(NUM_SLOTS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      readMode <= 1'b0;
      ofs      <= '0;
      doneCnt  <= '0;
    end else if (startBlk) begin
      active   <= 1'b1;
      readMode <= isRead;
      ofs      <= '0;
      doneCnt  <= '0;
    end else if (accept) begin
      ofs <= finish ? '0 : ofs + 1'b1;
      if (finish) doneCnt <= doneCnt + 1'b1;
      if (lastFlag || (finish && lastSlot)) active <= 1'b0;
      if (lastFlag) ofs <= '0;
    end
  end

  always_comb begin
    ctl.clrAll  = startBlk;
    ctl.accum   = accept;
    ctl.finish  = finish;
    ctl.drop    = accept && lastFlag && !finish;
    ctl.dec     = eccValid && readMode && !startBlk && ({1'b0, eccIdx} < doneCnt);
    ctl.ofs     = ofs;
    ctl.slot    = doneCnt[SLOT_W-1:0];
    ctl.decSlot = eccIdx;
  end

  assign busy       = active;
  assign blocksDone = doneCnt;
endmodule

// File: rtl/hecc_datapath.sv
`timescale 1ns/1ps
module hecc_datapath
  import hecc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  ctl_s                        ctl,
  input  logic [DATA_W-1:0]           dataByte,
  input  logic [CODE_W-1:0]           eccCode,
  output logic [NUM_SLOTS*CODE_W-1:0] codeVec,
  output logic [NUM_SLOTS*2-1:0]      statVec,
  output logic [NUM_SLOTS*OFS_W-1:0]  fixByteVec,
  output logic [NUM_SLOTS*BIT_W-1:0]  fixBitVec
);
  logic [ROW_W-1:0]  rowAcc, rowNext;
  logic [DATA_W-1:0] colAcc, colNext;
  logic              onesAcc, onesNext;
  logic              bytePar;
  logic [CODE_W-1:0] codeNext;

  logic [CODE_W-1:0] codeMem    [NUM_SLOTS];
  logic              onesMem    [NUM_SLOTS];
  stat_e             statMem    [NUM_SLOTS];
  logic [OFS_W-1:0]  fixByteMem [NUM_SLOTS];
  logic [BIT_W-1:0]  fixBitMem  [NUM_SLOTS];

  logic [CODE_W-1:0] syn;
  logic              pairOk;
  stat_e             decStat;
  logic [OFS_W-1:0]  decByte;
  logic [BIT_W-1:0]  decBit;

  // running parity including the byte presented this cycle
  always_comb begin
    bytePar = ^dataByte;
    rowNext = rowAcc;
    for (int i = 0; i < OFS_W; i++) begin
      if (ctl.ofs[i]) rowNext[2*i+1] = rowNext[2*i+1] ^ bytePar;
      else            rowNext[2*i]   = rowNext[2*i]   ^ bytePar;
    end
    colNext  = colAcc ^ dataByte;
    onesNext = onesAcc && (&dataByte);
    codeNext = {colFold(colNext), rowNext};
  end

  // syndrome decode for the requested slot
  always_comb begin
    syn    = eccCode ^ codeMem[ctl.decSlot];
    pairOk = 1'b1;
    for (int p = 0; p < CODE_W/2; p++) pairOk = pairOk && (syn[2*p] ^ syn[2*p+1]);
    decByte = '0;
    decBit  = '0;
    if (syn == '0 || (onesMem[ctl.decSlot] && (&eccCode))) begin
      decStat = ST_CLEAN;
    end else if (pairOk) begin
      decStat = ST_FIXED;
      for (int i = 0; i < OFS_W; i++) decByte[i] = syn[2*i+1];
      for (int j = 0; j < BIT_W; j++) decBit[j]  = syn[ROW_W+2*j+1];
    end else if ($countones(syn) == 1) begin
      decStat = ST_CODEFLT;
    end else begin
      decStat = ST_BAD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowAcc  <= '0;
      colAcc  <= '0;
      onesAcc <= 1'b1;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        codeMem[s]    <= '0;
        onesMem[s]    <= 1'b0;
        statMem[s]    <= ST_CLEAN;
        fixByteMem[s] <= '0;
        fixBitMem[s]  <= '0;
      end
    end else begin
      if (ctl.clrAll || ctl.finish || ctl.drop) begin
        rowAcc  <= '0;
        colAcc  <= '0;
        onesAcc <= 1'b1;
      end else if (ctl.accum) begin
        rowAcc  <= rowNext;
        colAcc  <= colNext;
        onesAcc <= onesNext;
      end
      if (ctl.finish) begin
        codeMem[ctl.slot] <= codeNext;
        onesMem[ctl.slot] <= onesNext;
      end
      if (ctl.clrAll) begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
          statMem[s]    <= ST_CLEAN;
          fixByteMem[s] <= '0;
          fixBitMem[s]  <= '0;
        end
      end else if (ctl.dec) begin
        statMem[ctl.decSlot]    <= decStat;
        fixByteMem[ctl.decSlot] <= decByte;
        fixBitMem[ctl.decSlot]  <= decBit;
      end
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gOut
    assign codeVec[g*CODE_W +: CODE_W]   = codeMem[g];
    assign statVec[g*2 +: 2]             = statMem[g];
    assign fixByteVec[g*OFS_W +: OFS_W]  = fixByteMem[g];
    assign fixBitVec[g*BIT_W +: BIT_W]   = fixBitMem[g];
  end
endmodule

// File: rtl/hamming_ecc_engine.sv
`timescale 1ns/1ps
module hamming_ecc_engine
  import hecc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startBlk,
  input  logic                        isRead,
  input  logic                        byteValid,
  input  logic [DATA_W-1:0]           dataByte,
  input  logic                        lastFlag,
  input  logic                        eccValid,
  input  logic [SLOT_W-1:0]           eccIdx,
  input  logic [CODE_W-1:0]           eccCode,
  output logic                        busy,
  output logic [SLOT_W:0]             blocksDone,
  output logic [NUM_SLOTS*CODE_W-1:0] codeVec,
  output logic [NUM_SLOTS*2-1:0]      statVec,
  output logic [NUM_SLOTS*OFS_W-1:0]  fixByteVec,
  output logic [NUM_SLOTS*BIT_W-1:0]  fixBitVec
);
  ctl_s ctl;

  hecc_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startBlk   (startBlk),
    .isRead     (isRead),
    .byteValid  (byteValid),
    .lastFlag   (lastFlag),
    .eccValid   (eccValid),
    .eccIdx     (eccIdx),
    .ctl        (ctl),
    .busy       (busy),
    .blocksDone (blocksDone)
  );

  hecc_datapath uData (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .dataByte   (dataByte),
    .eccCode    (eccCode),
    .codeVec    (codeVec),
    .statVec    (statVec),
    .fixByteVec (fixByteVec),
    .fixBitVec  (fixBitVec)
  );
endmodule

// File: rtl/hecc_checker.sv
`timescale 1ns/1ps
module hecc_checker
  import hecc_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        startBlk,
  input logic                        eccValid,
  input logic                        busy,
  input logic [SLOT_W:0]             blocksDone,
  input logic [NUM_SLOTS*CODE_W-1:0] codeVec,
  input logic [NUM_SLOTS*2-1:0]      statVec,
  input logic [NUM_SLOTS*OFS_W-1:0]  fixByteVec
);
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    startBlk |=> (busy && blocksDone == '0 && statVec == '0));

  assert_done_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    !startBlk |=> (blocksDone == $past(blocksDone) || blocksDone == $past(blocksDone) + 1'b1));

  assert_idle_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startBlk) |=> ($stable(blocksDone) && $stable(codeVec)));

  assert_slot_limit_R6: assert property (@(posedge clk) disable iff (!rstN)
    blocksDone <= (SLOT_W+1)'(NUM_SLOTS));

  assert_stat_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!startBlk && !eccValid) |=> $stable(statVec));

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gFix
    assert_fix_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
      (statVec[g*2 +: 2] != 2'd1) |-> (fixByteVec[g*OFS_W +: OFS_W] == '0));
  end
endmodule

bind hamming_ecc_engine hecc_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .startBlk   (startBlk),
  .eccValid   (eccValid),
  .busy       (busy),
  .blocksDone (blocksDone),
  .codeVec    (codeVec),
  .statVec    (statVec),
  .fixByteVec (fixByteVec)
);

// File: tb/hamming_ecc_engine_test.sv
`timescale 1ns/1ps
module hamming_ecc_engine_test;
  localparam int BLK = 512;
  localparam int NS  = 4;
  localparam int CW  = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startBlk = 1'b0, isRead = 1'b0, byteValid = 1'b0, lastFlag = 1'b0, eccValid = 1'b0;
  logic [7:0]  dataByte = '0;
  logic [1:0]  eccIdx = '0;
  logic [23:0] eccCode = '0;
  logic        busy;
  logic [2:0]  blocksDone;
  logic [95:0] codeVec;
  logic [7:0]  statVec;
  logic [35:0] fixByteVec;
  logic [11:0] fixBitVec;

  int checks = 0;
  int errs = 0;
  logic [7:0]  pageMem [NS*BLK];
  logic [7:0]  txMem   [NS*BLK];

  always #2 clk = ~clk;

  hamming_ecc_engine uut (
    .clk(clk), .rstN(rstN), .startBlk(startBlk), .isRead(isRead), .byteValid(byteValid),
    .dataByte(dataByte), .lastFlag(lastFlag), .eccValid(eccValid), .eccIdx(eccIdx),
    .eccCode(eccCode), .busy(busy), .blocksDone(blocksDone), .codeVec(codeVec),
    .statVec(statVec), .fixByteVec(fixByteVec), .fixBitVec(fixBitVec)
  );

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bit-by-bit reference code for the block at base
  function automatic logic [CW-1:0] refCode(int base);
    logic [CW-1:0] c = '0;
    for (int a = 0; a < BLK; a++)
      for (int b = 0; b < 8; b++)
        if (pageMem[base+a][b]) begin
          for (int i = 0; i < 9; i++) c[2*i + ((a >> i) & 1)] ^= 1'b1;
          for (int j = 0; j < 3; j++) c[18 + 2*j + ((b >> j) & 1)] ^= 1'b1;
        end
    return c;
  endfunction

  task automatic doStart(bit rd);
    @(negedge clk); startBlk = 1'b1; isRead = rd;
    @(negedge clk); startBlk = 1'b0;
  endtask

  task automatic sendRange(int base, int n, bit lastAtEnd);
    for (int k = 0; k < n; k++) begin
      if ($urandom % 6 == 0) begin @(negedge clk); byteValid = 1'b0; lastFlag = 1'b0; end
      @(negedge clk);
      byteValid = 1'b1; dataByte = txMem[base+k]; lastFlag = lastAtEnd && (k == n-1);
    end
    @(negedge clk); byteValid = 1'b0; lastFlag = 1'b0;
  endtask

  task automatic cmp(int idx, logic [CW-1:0] c);
    @(negedge clk); eccValid = 1'b1; eccIdx = 2'(idx); eccCode = c;
    @(negedge clk); eccValid = 1'b0;
  endtask

  task automatic fillRandom();
    for (int a = 0; a < NS*BLK; a++) begin
      pageMem[a] = 8'($urandom);
      txMem[a] = pageMem[a];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [CW-1:0] stored [NS];
    int            expStat [NS];
    int            expByte [NS];
    int            expBit [NS];
    logic [CW-1:0] saved;
    void'($urandom(32'h5EC0DE));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 blocksDone", blocksDone, 0);
    chk("R1 codeVec", codeVec[63:0], 0);
    chk("R1 status", {statVec, fixBitVec}, 0);

    // R3 R4 write page with last on the final byte
    fillRandom();
    doStart(1'b0);
    chk("R2 busy after start", busy, 1);
    sendRange(0, NS*BLK, 1'b1);
    chk("R4 blocksDone", blocksDone, NS);
    chk("R5 busy after last", busy, 0);
    for (int k = 0; k < NS; k++) chk("R3 code slot", codeVec[k*CW +: CW], refCode(k*BLK));
    // R12 compare in write session ignored
    cmp(0, ~refCode(0));
    chk("R12 write compare ignored", statVec, 0);

    // R6 auto close without last flag, R5 idle bytes ignored
    fillRandom();
    doStart(1'b0);
    sendRange(0, NS*BLK, 1'b0);
    chk("R6 closed", busy, 0);
    chk("R6 blocksDone", blocksDone, NS);
    saved = codeVec[0 +: CW];
    for (int a = 0; a < 20; a++) txMem[a] = ~pageMem[a];
    sendRange(0, 20, 1'b0);
    chk("R6 blocksDone after extra", blocksDone, NS);
    chk("R5 idle code stable", codeVec[0 +: CW], saved);

    // R2 byte on start cycle ignored
    fillRandom();
    @(negedge clk); startBlk = 1'b1; isRead = 1'b0; byteValid = 1'b1; dataByte = 8'h5A;
    @(negedge clk); startBlk = 1'b0; byteValid = 1'b0;
    chk("R2 busy", busy, 1);
    chk("R2 blocksDone", blocksDone, 0);
    sendRange(0, BLK, 1'b1);
    chk("R2 start byte ignored", codeVec[0 +: CW], refCode(0));
    chk("R4 one block", blocksDone, 1);

    // R5 partial block discarded
    saved = codeVec[0 +: CW];
    doStart(1'b0);
    sendRange(0, 100, 1'b1);
    chk("R5 partial busy", busy, 0);
    chk("R5 partial blocksDone", blocksDone, 0);
    chk("R5 partial no code", codeVec[0 +: CW], saved);

    // R7 R8 R9 R10 random read pages with injected faults
    for (int round = 0; round < 6; round++) begin
      fillRandom();
      for (int k = 0; k < NS; k++) begin
        int kind = (round < 2) ? ((k + round) % 4) : int'($urandom % 4);
        stored[k] = refCode(k*BLK);
        expByte[k] = 0; expBit[k] = 0;
        case (kind)
          0: expStat[k] = 0;
          1: begin
            expByte[k] = int'($urandom % BLK); expBit[k] = int'($urandom % 8);
            txMem[k*BLK + expByte[k]][expBit[k]] ^= 1'b1;
            expStat[k] = 1;
          end
          2: begin
            stored[k][$urandom % CW] ^= 1'b1;
            expStat[k] = 2;
          end
          default: begin
            int p1 = int'($urandom % (BLK*8));
            int p2 = (p1 + 1 + int'($urandom % (BLK*8 - 1))) % (BLK*8);
            txMem[k*BLK + p1/8][p1%8] ^= 1'b1;
            txMem[k*BLK + p2/8][p2%8] ^= 1'b1;
            expStat[k] = 3;
          end
        endcase
      end
      doStart(1'b1);
      sendRange(0, NS*BLK, 1'b1);
      for (int k = 0; k < NS; k++) begin
        cmp(k, stored[k]);
        case (expStat[k])
          0: chk("R7 clean", statVec[k*2 +: 2], 0);
          1: chk("R8 fixed", statVec[k*2 +: 2], 1);
          2: chk("R9 code fault", statVec[k*2 +: 2], 2);
          default: chk("R10 uncorrectable", statVec[k*2 +: 2], 3);
        endcase
        chk("R8 R10 byte", fixByteVec[k*9 +: 9], 64'(expByte[k]));
        chk("R8 R10 bit", fixBitVec[k*3 +: 3], 64'(expBit[k]));
      end
      // R2 start clears statuses
      doStart(1'b1);
      chk("R2 status cleared", statVec, 0);
    end

    // R11 erased block, R12 compare to incomplete slot
    for (int a = 0; a < NS*BLK; a++) begin pageMem[a] = 8'hFF; txMem[a] = 8'hFF; end
    doStart(1'b1);
    sendRange(0, BLK, 1'b1);
    cmp(0, 24'hFFFFFF);
    chk("R11 erased clean", statVec[1:0], 0);
    cmp(0, 24'h000000);
    chk("R7 erased zero code", statVec[1:0], 0);
    cmp(2, 24'h000123);
    chk("R12 incomplete slot ignored", statVec, 0);

    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule